// File: doc/BRIEF.md
# External Bus Hold Arbitration Controller

This block lets a local bus controller share one external bus with other bus masters through three active-low handshake pins: a hold request input, a hold-acknowledge pin and a bus request output. It sits beside the bus cycle engine. It tells that engine when it may drive the bus and when a new access must wait. It does not generate bus cycles and does not decode addresses.

The same block acts as either side of the handshake, chosen by one mode bit. In master mode it owns the bus after reset. When another device asks for the bus, it waits for the current cycle to finish, floats its outputs and then acknowledges. In slave mode the acknowledge pin becomes an input. The block starts without the bus, raises its request when a local access is pending, and takes the bus only when the acknowledge is seen. Because the acknowledge pin turns around with the mode, the request output of one controller can be wired to the hold input of another, and the two acknowledge pins can be wired together, with no extra logic. Arbitration stays off until an enable bit is set. While it is off, the local side owns the bus and the pins are left idle.

Top module: `hold_arbiter`

## Requirements
- R1: While `arb_en` is 0, the block holds `bus_oe_o`=1, `loc_stall_o`=0, `breq_n_o`=1, `hlda_n_o`=1 and `hlda_oe_o`=0, whatever happens on `hold_n_i`.
- R2: `hlda_oe_o` is 1 when arbitration is enabled in master mode (`slave_mode`=0), and 0 in slave mode (`slave_mode`=1), where the acknowledge pin is an input.
- R3: In master mode, `hold_n_i` passes through a two-flop synchroniser. If `hold_n_i` goes low before edge k and `cyc_busy` is low, `bus_oe_o` stays 1 after edges k and k+1 and falls to 0 at edge k+2.
- R4: In master mode, `hlda_n_o` goes low exactly one clock after `bus_oe_o` falls. Until then it stays high.
- R5: In master mode, while the bus is granted away (`hlda_n_o`=0), `breq_n_o` is 0 exactly when `loc_req` is 1.
- R6: In master mode, when `hold_n_i` returns high before edge k, `hlda_n_o` goes high and `bus_oe_o` goes high together at edge k+2.
- R7: `loc_stall_o` is 1 whenever the block does not drive the bus (`bus_oe_o`=0).
- R8: In slave mode, the block comes out of reset or disable without the bus (`bus_oe_o`=0). A pending `loc_req` drives `breq_n_o` low at the next edge, and `breq_n_o` stays low while the bus is owned.
- R9: In slave mode, `bus_oe_o` rises only after `hlda_n_i` low has passed the two-flop synchroniser. If `hlda_n_i` falls before edge k, the bus is taken at edge k+2.
- R10: In slave mode, the owned bus is given back (`breq_n_o`=1, `bus_oe_o`=0) when no cycle is running and either `loc_req` is 0 or the synchronised `hold_n_i` is low. No new request is raised until `hlda_n_i` has been seen high.
- R11: In either mode, the bus is never released while `cyc_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbitration enable |
| slave_mode | input | 1 | 0 = master (grants the bus), 1 = slave (requests the bus) |
| loc_req | input | 1 | A local access is pending |
| cyc_busy | input | 1 | A local bus cycle is in progress |
| hold_n_i | input | 1 | Hold request pin, active low |
| hlda_n_i | input | 1 | Hold-acknowledge pin as input (slave mode), active low |
| hlda_n_o | output | 1 | Hold-acknowledge pin as output (master mode), active low |
| hlda_oe_o | output | 1 | Output enable of the hold-acknowledge pin |
| breq_n_o | output | 1 | Bus request pin, active low |
| bus_oe_o | output | 1 | Local bus outputs driven when 1, floated when 0 |
| loc_stall_o | output | 1 | Local access must wait |

## Verification
Some rules are checked by the assertions on every cycle. A release never follows a cycle that was still busy. The acknowledge never comes before the bus floats. Stall always covers a floated bus. A slave never takes the bus without a synchronised acknowledge, and the request stays asserted while the bus is owned. The exact latencies can only be shown by the bench scenarios: two flops of synchronisation plus one state edge, one more clock to the acknowledge, and simultaneous re-drive on release. The same holds for the ignored hold input while disabled, and for the refusal to re-request before the acknowledge goes high. The bench sweeps cycle lengths, request levels and release causes in both modes.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [1:0] {
    MST_OWN   = 2'd0,
    MST_FLOAT = 2'd1,
    MST_GRANT = 2'd2
  } mst_state_t;

  typedef enum logic [1:0] {
    SLV_IDLE = 2'd0,
    SLV_REQ  = 2'd1,
    SLV_OWN  = 2'd2,
    SLV_WAIT = 2'd3
  } slv_state_t;

  // master gives the bus away only between cycles
  function automatic logic mst_take(input logic owning, input logic hold_act,
                                    input logic busy);
    return owning && hold_act && !busy;
  endfunction

  // slave hands the bus back when idle and either done or asked to
  function automatic logic slv_release(input logic owning, input logic busy,
                                       input logic req, input logic hold_act);
    return owning && !busy && (!req || hold_act);
  endfunction

endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hold_arb_master.sv
module hold_arb_master
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_act_i,
  input  logic cyc_busy_i,
  input  logic loc_req_i,
  output logic bus_oe_o,
  output logic hlda_n_o,
  output logic breq_n_o,
  output logic stall_o
);
  mst_state_t st_q, st_d;
  logic take_w;

  assign take_w = mst_take(st_q == MST_OWN, hold_act_i, cyc_busy_i);

  always_comb begin
    st_d = st_q;
    case (st_q)
      MST_OWN:   if (take_w) st_d = MST_FLOAT;
      MST_FLOAT: st_d = hold_act_i ? MST_GRANT : MST_OWN;
      MST_GRANT: if (!hold_act_i) st_d = MST_OWN;
      default:   st_d = MST_OWN;
    endcase
    if (!en_i) st_d = MST_OWN;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= MST_OWN;
    else        st_q <= st_d;

  assign bus_oe_o = (st_q == MST_OWN);
  assign hlda_n_o = (st_q != MST_GRANT);
  assign breq_n_o = !((st_q == MST_GRANT) && loc_req_i);
  assign stall_o  = (st_q != MST_OWN) || take_w;

  AST_MST_NO_EARLY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    $fell(bus_oe_o) |-> (!$past(cyc_busy_i) && $past(hold_act_i))); // R11
  AST_MST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    $fell(hlda_n_o) |-> (!$past(bus_oe_o) && !bus_oe_o)); // R4
  AST_MST_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    $rose(hlda_n_o) |-> bus_oe_o); // R6
  AST_MST_BREQ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    (!hlda_n_o && loc_req_i) |-> !breq_n_o); // R5
endmodule

// File: rtl/hold_arb_slave.sv
module hold_arb_slave
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_act_i,
  input  logic hlda_act_i,
  input  logic cyc_busy_i,
  input  logic loc_req_i,
  output logic bus_oe_o,
  output logic breq_n_o,
  output logic stall_o
);
  slv_state_t st_q, st_d;
  logic rel_w;

  assign rel_w = slv_release(st_q == SLV_OWN, cyc_busy_i, loc_req_i, hold_act_i);

  always_comb begin
    st_d = st_q;
    case (st_q)
      SLV_IDLE: if (loc_req_i) st_d = SLV_REQ;
      SLV_REQ:  if (!loc_req_i) st_d = SLV_WAIT;
                else if (hlda_act_i) st_d = SLV_OWN;
      SLV_OWN:  if (rel_w) st_d = SLV_WAIT;
      SLV_WAIT: if (!hlda_act_i) st_d = SLV_IDLE;
      default:  st_d = SLV_IDLE;
    endcase
    if (!en_i) st_d = SLV_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= SLV_IDLE;
    else        st_q <= st_d;

  assign bus_oe_o = (st_q == SLV_OWN);
  assign breq_n_o = !((st_q == SLV_REQ) || (st_q == SLV_OWN));
  assign stall_o  = (st_q != SLV_OWN) || rel_w;

  AST_SLV_OWN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    $rose(bus_oe_o) |-> $past(hlda_act_i)); // R9
  AST_SLV_OWN_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    bus_oe_o |-> !breq_n_o); // R8
  AST_SLV_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    $fell(bus_oe_o) |-> !$past(cyc_busy_i)); // R11
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en,
  input  logic slave_mode,
  input  logic loc_req,
  input  logic cyc_busy,
  input  logic hold_n_i,
  input  logic hlda_n_i,
  output logic hlda_n_o,
  output logic hlda_oe_o,
  output logic breq_n_o,
  output logic bus_oe_o,
  output logic loc_stall_o
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_sync;
  logic hold_act, hlda_act;
  logic mst_en, slv_en;
  logic m_bus_oe, m_hlda_n, m_breq_n, m_stall;
  logic s_bus_oe, s_breq_n, s_stall;

  hold_arb_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i({hlda_n_i, hold_n_i}), .q_o(pins_sync));

  assign hold_act = !pins_sync[0];
  assign hlda_act = !pins_sync[1];
  assign mst_en   = arb_en && !slave_mode;
  assign slv_en   = arb_en && slave_mode;

  hold_arb_master mst_i (
    .clk(clk), .rst_n(rst_n), .en_i(mst_en), .hold_act_i(hold_act),
    .cyc_busy_i(cyc_busy), .loc_req_i(loc_req),
    .bus_oe_o(m_bus_oe), .hlda_n_o(m_hlda_n), .breq_n_o(m_breq_n), .stall_o(m_stall));

  hold_arb_slave slv_i (
    .clk(clk), .rst_n(rst_n), .en_i(slv_en), .hold_act_i(hold_act),
    .hlda_act_i(hlda_act), .cyc_busy_i(cyc_busy), .loc_req_i(loc_req),
    .bus_oe_o(s_bus_oe), .breq_n_o(s_breq_n), .stall_o(s_stall));

  always_comb begin
    hlda_oe_o   = 1'b0;
    hlda_n_o    = 1'b1;
    breq_n_o    = 1'b1;
    bus_oe_o    = 1'b1;
    loc_stall_o = 1'b0;
    if (mst_en) begin
      hlda_oe_o   = 1'b1;
      hlda_n_o    = m_hlda_n;
      breq_n_o    = m_breq_n;
      bus_oe_o    = m_bus_oe;
      loc_stall_o = m_stall;
    end else if (slv_en) begin
      breq_n_o    = s_breq_n;
      bus_oe_o    = s_bus_oe;
      loc_stall_o = s_stall;
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> (bus_oe_o && !loc_stall_o && breq_n_o && hlda_n_o && !hlda_oe_o)); // R1
  AST_STALL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> loc_stall_o); // R7
  AST_HLDA_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !hlda_oe_o); // R2
endmodule

// File: tb/hold_arbiter_tb_top.sv
module hold_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, arb_en, slave_mode, loc_req, cyc_busy, hold_n_i, hlda_n_i;
  logic hlda_n_o, hlda_oe_o, breq_n_o, bus_oe_o, loc_stall_o;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .slave_mode(slave_mode),
    .loc_req(loc_req), .cyc_busy(cyc_busy), .hold_n_i(hold_n_i), .hlda_n_i(hlda_n_i),
    .hlda_n_o(hlda_n_o), .hlda_oe_o(hlda_oe_o), .breq_n_o(breq_n_o),
    .bus_oe_o(bus_oe_o), .loc_stall_o(loc_stall_o));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; arb_en = 0; slave_mode = 0; loc_req = 0; cyc_busy = 0;
    hold_n_i = 1; hlda_n_i = 1;
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset and disabled state
    chk("R1 bus_oe", bus_oe_o, 1'b1);
    chk("R1 stall", loc_stall_o, 1'b0);
    chk("R1 breq_n", breq_n_o, 1'b1);
    chk("R1 hlda_n", hlda_n_o, 1'b1);
    chk("R1 hlda_oe", hlda_oe_o, 1'b0);
    hold_n_i = 0; loc_req = 1;
    step(5);
    chk("R1 hold ignored bus_oe", bus_oe_o, 1'b1);
    chk("R1 hold ignored hlda_n", hlda_n_o, 1'b1);
    chk("R1 hold ignored stall", loc_stall_o, 1'b0);
    hold_n_i = 1; loc_req = 0;
    step(3);

    arb_en = 1;
    step(1);
    chk("R2 master drives hlda", hlda_oe_o, 1'b1);

    // master sweep: cycle length x local request level
    for (int bl = 0; bl < 4; bl++) begin
      for (int lr = 0; lr < 2; lr++) begin
        cyc_busy = (bl > 0); loc_req = lr[0]; hold_n_i = 0;
        step(1);
        chk("R3 sync stage1", bus_oe_o, 1'b1);
        step(1);
        chk("R3 sync stage2", bus_oe_o, 1'b1);
        for (int k = 0; k < bl; k++) begin
          step(1);
          chk("R11 busy keeps bus", bus_oe_o, 1'b1);
        end
        cyc_busy = 0;
        step(1);
        chk("R3 float", bus_oe_o, 1'b0);
        chk("R4 no early ack", hlda_n_o, 1'b1);
        chk("R7 stall on float", loc_stall_o, 1'b1);
        step(1);
        chk("R4 ack", hlda_n_o, 1'b0);
        chk("R5 breq", breq_n_o, !lr[0]);
        loc_req = !lr[0];
        step(1);
        chk("R5 breq follows", breq_n_o, lr[0]);
        hold_n_i = 1;
        step(2);
        chk("R6 ack held during sync", hlda_n_o, 1'b0);
        step(1);
        chk("R6 ack off", hlda_n_o, 1'b1);
        chk("R6 redrive", bus_oe_o, 1'b1);
        loc_req = 0;
        step(2);
        chk("R7 no stall when owning", loc_stall_o, 1'b0);
      end
    end

    // slave mode
    arb_en = 0; slave_mode = 1;
    step(1);
    chk("R1 slave disabled bus_oe", bus_oe_o, 1'b1);
    arb_en = 1;
    step(1);
    chk("R2 slave hlda input", hlda_oe_o, 1'b0);
    chk("R8 start without bus", bus_oe_o, 1'b0);
    chk("R7 slave stall", loc_stall_o, 1'b1);

    for (int hr = 0; hr < 2; hr++) begin
      for (int bl = 0; bl < 3; bl++) begin
        loc_req = 1;
        step(1);
        chk("R8 request", breq_n_o, 1'b0);
        chk("R8 no bus yet", bus_oe_o, 1'b0);
        hlda_n_i = 0;
        step(2);
        chk("R9 ack still syncing", bus_oe_o, 1'b0);
        step(1);
        chk("R9 bus taken", bus_oe_o, 1'b1);
        chk("R8 request held while owning", breq_n_o, 1'b0);
        chk("R7 no stall when owning", loc_stall_o, 1'b0);
        cyc_busy = (bl > 0);
        if (hr == 1) hold_n_i = 0; else loc_req = 0;
        for (int k = 0; k < 2 * hr; k++) begin
          step(1);
          chk("R10 hold syncing", bus_oe_o, 1'b1);
        end
        for (int k = 0; k < bl; k++) begin
          step(1);
          chk("R11 busy keeps bus", bus_oe_o, 1'b1);
        end
        cyc_busy = 0;
        step(1);
        chk("R10 released bus", bus_oe_o, 1'b0);
        chk("R10 released breq", breq_n_o, 1'b1);
        loc_req = 1; hold_n_i = 1;
        step(2);
        chk("R10 no re-request before ack high", breq_n_o, 1'b1);
        hlda_n_i = 1;
        step(3);
        chk("R10 idle after ack high", breq_n_o, 1'b1);
        step(1);
        chk("R8 re-request", breq_n_o, 1'b0);
        loc_req = 0;
        step(4);
        chk("R8 request dropped", breq_n_o, 1'b1);
      end
    end

    arb_en = 0;
    step(1);
    chk("R1 disabled again bus_oe", bus_oe_o, 1'b1);
    chk("R1 disabled again stall", loc_stall_o, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule